// File: doc/BRIEF.md
# GF(2^128) Field Multiplier with Optional Bit Reflection

This block multiplies two 128-bit elements of the binary field GF(2^128) and reduces the product by the polynomial x^128 + x^7 + x^2 + x + 1. It is the core operation of the authentication hash in GCM and GMAC. The multiplier is iterative. A single-cycle start pulse loads both operands. The unit then spends a fixed number of clock cycles running a shift-and-add loop. A one-cycle done pulse marks the moment the registered result becomes valid, and the result stays on the output until the next multiply finishes.

A reflection input selects the bit ordering. With reflection off, bit i of each operand and of the result is the coefficient of x^i, which is the plain polynomial basis. With reflection on, both operands are bit-reversed across all 128 bits before the multiply, and the product is reversed again before it is registered. The same plain multiplier therefore serves the reflected convention that GCM uses.

The parameter `DIGIT` sets how many multiplier bits are consumed per clock. The multiply takes `W/DIGIT` cycles, and the default value of `DIGIT` is 1.

Top module: `gf128_mult`

## Requirements
- R1: With `mode_i` low, `result_o` is the product of `op_a_i` and `op_b_i` modulo x^128 + x^7 + x^2 + x + 1, where bit i of each vector is the coefficient of x^i.
- R2: Reduction folds the overflow term x^128 into x^7 + x^2 + x + 1. For example, x^127 times x gives 0x87.
- R3: With `mode_i` high, `result_o` equals rev(rev(a) * rev(b)), where rev(v)[i] = v[127-i]. In this convention, the GCM operands 66e94bd4ef8a2c3b884cfa59ca342b2e and 0388dace60b6a392f328c2b971b2fe78 give 5e2ec746917062882c85b0685353deb7.
- R4: A start that is sampled high at a clock edge while the unit is idle is accepted. `done_o` is then high for exactly one cycle, following the edge that comes W/DIGIT edges after the accepting edge.
- R5: A start that arrives while the unit is busy is ignored. It does not change the result, and it does not change the done timing.
- R6: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`. `result_o` holds its value at all times except when a multiply completes.
- R7: While the synchronous active-high reset `rst_i` is high, it clears `busy_o`, `done_o` and `result_o` and abandons any multiply in progress. The abandoned multiply never produces a done pulse.
- R8: The operands and `mode_i` are sampled only on the accepting edge. Changes to them while the unit is busy do not affect the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted only when the unit is idle |
| mode_i | input | 1 | 1 = reflect both operands and the result |
| op_a_i | input | 128 | First operand |
| op_b_i | input | 128 | Second operand |
| busy_o | output | 1 | A multiply is in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| result_o | output | 128 | Registered field product |

## Verification
The bench builds the block with its default parameters: a 128-bit field and a `DIGIT` of 1. With these values every one of the 128 iterations runs, including the late steps in which the multiplicand's top bit overflows and the reduction constant is folded in. The bench also checks the full 128-cycle latency against a cycle counter of its own. The reference model works independently of the design. It forms the 255-bit carry-less product and reduces it from the top down. A published GCM hash vector anchors the reflected mode against a value that does not come from the model.

// File: rtl/gf128_pkg.sv
package gf128_pkg;
  localparam int unsigned FIELD_W = 128;
  // low-order terms of the field polynomial (x^7 + x^2 + x + 1)
  localparam logic [FIELD_W-1:0] FIELD_TAIL = 128'h87;
endpackage

// File: rtl/gf128_reflect.sv
module gf128_reflect #(
  parameter int unsigned W = 128
) (
  input  logic         en_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout_o[i] = en_i ? din_i[W-1-i] : din_i[i];
  end
endmodule

// File: rtl/gf128_digit.sv
module gf128_digit #(
  parameter int unsigned W     = 128,
  parameter logic [W-1:0] TAIL = 128'h87,
  parameter int unsigned DIGIT = 1
) (
  input  logic [W-1:0]     acc_i,
  input  logic [W-1:0]     mcand_i,
  input  logic [DIGIT-1:0] mbits_i,
  output logic [W-1:0]     acc_o,
  output logic [W-1:0]     mcand_o
);
  logic [W-1:0] acc_c   [DIGIT+1];
  logic [W-1:0] mcand_c [DIGIT+1];

  assign acc_c[0]   = acc_i;
  assign mcand_c[0] = mcand_i;

  for (genvar g = 0; g < DIGIT; g++) begin : g_step
    // conditional accumulate, then multiply the multiplicand by x and reduce
    assign acc_c[g+1]   = mbits_i[g] ? (acc_c[g] ^ mcand_c[g]) : acc_c[g];
    assign mcand_c[g+1] = {mcand_c[g][W-2:0], 1'b0} ^ (mcand_c[g][W-1] ? TAIL : '0);
  end

  assign acc_o   = acc_c[DIGIT];
  assign mcand_o = mcand_c[DIGIT];
endmodule

// File: rtl/gf128_ctrl.sv
module gf128_ctrl #(
  parameter int unsigned STEPS = 128,
  localparam int unsigned CW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  logic          busy_q;
  logic          done_q;
  logic [CW-1:0] cnt_q;
  logic          rst_seen_q;

  assign load_o = start_i && !busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q && (cnt_q == CW'(STEPS - 1));
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (last_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rst_seen_q <= 1'b1;
  end

  // R4: an idle start is taken on the next edge
  a_r4_start_accept: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !busy_q) |=> busy_q);
  // R4: done never lasts more than one cycle
  a_r4_done_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
    done_q |=> !done_q);
  // R5: a start during busy neither restarts nor stalls the count
  a_r5_start_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && start_i && !last_o) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));
  // R6: busy and done are never high together
  a_r6_busy_done_excl: assert property (@(posedge clk_i) disable iff (rst_i)
    done_q |-> !busy_q);
  // R7: a reset cycle leaves the unit idle with no done pulse
  a_r7_reset_idle: assert property (@(posedge clk_i)
    (rst_seen_q === 1'b1 && $past(rst_i) === 1'b1) |-> (!busy_q && !done_q));
endmodule

// File: rtl/gf128_mult.sv
module gf128_mult #(
  parameter int unsigned  W     = gf128_pkg::FIELD_W,
  parameter logic [W-1:0] TAIL  = gf128_pkg::FIELD_TAIL,
  parameter int unsigned  DIGIT = 1,
  localparam int unsigned STEPS = W / DIGIT
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  logic         load, step, last;
  logic [W-1:0] a_ref, b_ref, res_ref;
  logic [W-1:0] acc_q, mcand_q, mult_q, result_q;
  logic [W-1:0] acc_nx, mcand_nx;
  logic         mode_q;
  logic         rst_seen_q;

  gf128_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .last_o (last),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  gf128_reflect #(.W(W)) u_ref_a (.en_i(mode_i), .din_i(op_a_i), .dout_o(a_ref));
  gf128_reflect #(.W(W)) u_ref_b (.en_i(mode_i), .din_i(op_b_i), .dout_o(b_ref));

  gf128_digit #(.W(W), .TAIL(TAIL), .DIGIT(DIGIT)) u_digit (
    .acc_i  (acc_q),
    .mcand_i(mcand_q),
    .mbits_i(mult_q[DIGIT-1:0]),
    .acc_o  (acc_nx),
    .mcand_o(mcand_nx)
  );

  gf128_reflect #(.W(W)) u_ref_r (.en_i(mode_q), .din_i(acc_nx), .dout_o(res_ref));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mult_q   <= '0;
      mode_q   <= 1'b0;
      result_q <= '0;
    end else if (load) begin
      acc_q   <= '0;
      mcand_q <= a_ref;
      mult_q  <= b_ref;
      mode_q  <= mode_i;
    end else if (step) begin
      acc_q   <= acc_nx;
      mcand_q <= mcand_nx;
      mult_q  <= mult_q >> DIGIT;
      if (last) result_q <= res_ref;
    end
  end

  assign result_o = result_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) rst_seen_q <= 1'b1;
  end

  // R6: the result moves only on a completing edge (or a reset)
  a_r6_result_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (rst_seen_q === 1'b1 && !$past(rst_i) && !done_o) |-> $stable(result_o));
  // R7: reset empties the result register
  a_r7_result_clear: assert property (@(posedge clk_i)
    (rst_seen_q === 1'b1 && $past(rst_i) === 1'b1) |-> (result_o == '0));
endmodule

// File: tb/tb_gf128_mult.sv
module tb_gf128_mult;
  localparam int CLK_PERIOD = 10;
  localparam int W = 128;
  localparam int LAT = 129; // negedges from drive to visible done

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int unsigned  checks = 0, fails = 0, dones = 0, pushes = 0;
  longint       cyc = 0;
  logic [W-1:0] exp_q[$];
  longint       cyc_q[$];
  string        tag_q[$];
  logic [W-1:0] last_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  gf128_mult dut (
    .clk_i(clk), .rst_i(rst), .start_i(start), .mode_i(mode),
    .op_a_i(op_a), .op_b_i(op_b),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  // carry-less product, then reduce from the top down
  function automatic logic [W-1:0] gf_ref(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] p = '0;
    for (int i = 0; i < W; i++) if (b[i]) p ^= ({{W{1'b0}}, a} << i);
    for (int k = 2*W-2; k >= W; k--) begin
      if (p[k]) begin
        p[k] = 1'b0;
        p[k-121] ^= 1'b1;
        p[k-126] ^= 1'b1;
        p[k-127] ^= 1'b1;
        p[k-128] ^= 1'b1;
      end
    end
    return p[W-1:0];
  endfunction

  function automatic logic [W-1:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: push expected value, pulse start
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic m,
                        input logic [W-1:0] exp, input string tag);
    while (busy) @(negedge clk);
    op_a = a; op_b = b; mode = m; start = 1'b1;
    exp_q.push_back(exp); cyc_q.push_back(cyc); tag_q.push_back(tag);
    pushes++;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pop and compare on each done
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (done) begin
      dones++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5/R7 unexpected done", result, '0);
      end else begin
        logic [W-1:0] e;
        longint c;
        string t;
        e = exp_q.pop_front(); c = cyc_q.pop_front(); t = tag_q.pop_front();
        last_exp = e;
        chk(result == e, t, result, e);
        chk((cyc - c) == LAT, "R4 latency", W'(cyc - c), W'(LAT));
      end
      chk(!done_prev, "R4 done width", W'(done_prev), '0);
    end
    done_prev <= done;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", '0, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b;
    int unsigned d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: reset state
    chk(!busy, "R7 busy after reset", W'(busy), '0);
    chk(!done, "R7 done after reset", W'(done), '0);
    chk(result == '0, "R7 result after reset", result, '0);

    // R1: identities and simple products
    run_op(128'h1, 128'h2, 1'b0, 128'h2, "R1 one*x");
    chk(busy, "R6 busy during op", W'(busy), W'(1));
    run_op(128'h0123456789abcdef0011223344556677, 128'h1, 1'b0,
           128'h0123456789abcdef0011223344556677, "R1 a*one");
    run_op(rnd128(), '0, 1'b0, '0, "R1 a*zero");
    // R2: reduction of x^128
    run_op(128'h1 << 127, 128'h2, 1'b0, 128'h87, "R2 x127*x");
    run_op(128'h1 << 127, 128'h1 << 127, 1'b0, gf_ref(128'h1 << 127, 128'h1 << 127), "R2 x127*x127");
    for (int i = 0; i < 4; i++) begin
      a = rnd128(); b = rnd128();
      run_op(a, b, 1'b0, gf_ref(a, b), "R1 random plain");
    end
    // R3: reflected mode
    run_op(128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 128'h0388dace60b6a392f328c2b971b2fe78, 1'b1,
           128'h5e2ec746917062882c85b0685353deb7, "R3 gcm vector");
    for (int i = 0; i < 3; i++) begin
      a = rnd128(); b = rnd128();
      run_op(a, b, 1'b1, rev(gf_ref(rev(a), rev(b))), "R3 random reflected");
    end
    drain();

    // R6: result holds after done
    repeat (40) @(negedge clk);
    chk(result == last_exp, "R6 result hold", result, last_exp);

    // R5 and R8: start and operand changes during busy
    a = rnd128(); b = rnd128();
    run_op(a, b, 1'b0, gf_ref(a, b), "R5/R8 result unaffected");
    repeat (10) @(negedge clk);
    op_a = rnd128(); op_b = rnd128(); mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_a = '1; op_b = '1;
    drain();
    d0 = dones;
    repeat (140) @(negedge clk);
    chk(dones == d0, "R5 no extra done", W'(dones), W'(d0));

    // R7: reset mid-operation abandons it
    op_a = rnd128(); op_b = rnd128(); mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy, "R7 busy cleared mid-op", W'(busy), '0);
    chk(result == '0, "R7 result cleared mid-op", result, '0);
    d0 = dones;
    repeat (140) @(negedge clk);
    chk(dones == d0, "R7 no done from abandoned op", W'(dones), W'(d0));

    // R4: a start right after done is accepted
    a = rnd128(); b = rnd128();
    run_op(a, b, 1'b1, rev(gf_ref(rev(a), rev(b))), "R4 back-to-back A");
    a = rnd128(); b = rnd128();
    run_op(a, b, 1'b0, gf_ref(a, b), "R4 back-to-back B");
    drain();

    chk(dones == pushes, "R4 done count", W'(dones), W'(pushes));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule